// File: doc/BRIEF.md
# Debug Register Scan Port

This block is a 38-bit scan data register that a JTAG TAP controller places between TDI and TDO so that an external debugger can reach a small file of on-chip debug registers. The file holds a debug control register, a debug status view, an optional vector-catch register, two watchpoint units of six registers each, and a two-way word channel to the core, made of a read-only channel control register and a 32-bit channel data register.

An update writes when the direction bit is set. In every case the update also latches the address, so read data comes out of the capture of the next scan. Capturing the channel data register consumes the word waiting there. A debugger therefore finishes a read sequence with the address parked on the channel control register, whose capture has no side effect. The core side has a write strobe with a data word, a read strobe and two status flags. Every flag crosses between the test clock and the core clock through a toggle handshake.

Top module: `dbgscan_port`

## Requirements
- R1: The scan register is 38 bits, shifted LSB first from TDI toward TDO while `shiftDr` is high. Bits 31:0 are data, bits 36:32 are the register address and bit 37 is the direction (1 = write, 0 = read).
- R2: On `updDr` with bit 37 set, the data field is written to the addressed register. Every update, write or read, latches bits 36:32 as the current address.
- R3: On `capDr`, the scan register loads the content of the latched address into bits 31:0, the latched address into bits 36:32 and 0 into bit 37. Read data therefore appears one scan after the update that named the address.
- R4: The channel control register (address 4) is read-only. Bits 31:28 carry the `VERSION` parameter, bit 0 is 1 while a debugger word waits for the core, bit 1 is 1 while a core word waits for the debugger, and all other bits read as 0.
- R5: Debug control (address 0) is 3 bits wide at version 1, 4 bits at version 2 and 6 bits otherwise. Debug status (address 1) returns `statusIn` cut to 10 bits at version 7 and to 5 bits otherwise. Bits above a register's width read as 0 and appear as 0 on the outputs.
- R6: Bit 4 of debug control appears on `dbgCtrl[4]` as the monitor-mode enable. Writing 0 to that bit selects halting debug.
- R7: Address 2 is an 8-bit vector-catch register when `HAS_VCATCH` is 1 and reads as 0 otherwise. Addresses 8 to 13 belong to watchpoint unit 0 and 16 to 21 to unit 1, each in the order address value, address mask, data value, data mask, control value, control mask. The two control registers of each unit are 9 bits wide and the other four are 32 bits.
- R8: Unmapped addresses read as 0 and ignore writes.
- R9: A debugger write to the channel data register (address 5) raises `coreRxValid` and presents the word on `coreRdData`. A write made while the previous word is still pending is ignored.
- R10: `coreRdStb` while `coreRxValid` is high clears `coreRxValid` on the next core clock edge, and bit 0 of channel control then clears.
- R11: `coreWrStb` while `coreTxBusy` is low stores `coreWrData` and raises `coreTxBusy`, and bit 1 of channel control then sets. A core write made while busy is ignored.
- R12: A capture at address 5 while a core word waits returns that word and consumes it: bit 1 clears and `coreTxBusy` falls. A capture at address 4 changes no flag.
- R13: After reset, both flags are 0, every register reads 0 and `dbgCtrl`, `vecCatch` and `wpRegs` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| capDr | input | 1 | Capture state of the TAP, one test-clock cycle |
| shiftDr | input | 1 | Shift state of the TAP |
| updDr | input | 1 | Update state of the TAP, one test-clock cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the scan register |
| clk | input | 1 | Core clock |
| coreWrStb | input | 1 | Core posts a word to the debugger |
| coreWrData | input | 32 | Word posted by the core |
| coreRdStb | input | 1 | Core takes the debugger's word |
| coreRdData | output | 32 | Word from the debugger |
| coreRxValid | output | 1 | Debugger word available to the core |
| coreTxBusy | output | 1 | Core word not yet consumed by the debugger |
| statusIn | input | 10 | Live debug status bits |
| dbgCtrl | output | 6 | Debug control register, bit 4 monitor enable |
| vecCatch | output | VC_W | Vector-catch register |
| wpRegs | output | 12x32 | Watchpoint registers, unit 0 in entries 0 to 5, unit 1 in entries 6 to 11 |

## Verification
The hardest case to reach is the interaction of the channel with the one-scan read delay. The data register is consumed by whichever capture follows the update that named it, so parking on the control register has to be shown to leave a waiting core word untouched while reading the data register takes it. The bench posts a core word, then a second one while the first is still busy. It reads channel control twice in a row, parked on address 4, and checks that the flag and `coreTxBusy` survive. Only then does it read address 5 through the scan that re-parks the address, and it checks that the first word comes back and that both flags clear after the crossing.

// File: rtl/dbgscan_pkg.sv
package dbgscan_pkg;

  localparam int SCAN_W     = 38;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 5;
  localparam int CTRL_MAX_W = 6;
  localparam int STAT_MAX_W = 10;
  localparam int WP_UNITS   = 2;
  localparam int WP_PER     = 6;
  localparam int WP_TOTAL   = WP_UNITS * WP_PER;

  // Addresses a debugger relies on
  localparam logic [ADDR_W-1:0] A_DCTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_DSTAT  = 5'd1;
  localparam logic [ADDR_W-1:0] A_VCATCH = 5'd2;
  localparam logic [ADDR_W-1:0] A_CHCTRL = 5'd4;
  localparam logic [ADDR_W-1:0] A_CHDATA = 5'd5;
  localparam logic [ADDR_W-1:0] A_WP0    = 5'd8;
  localparam logic [ADDR_W-1:0] A_WP1    = 5'd16;

  // Strobes from control to datapath, all in the test clock domain
  typedef struct packed {
    logic load;     // capture
    logic shift;    // shift toward tdo
    logic write;    // update with direction bit set
    logic post;     // accepted debugger word for the core
    logic consume;  // capture that takes the core's word
  } scanStrb_t;

  function automatic int ctrlWidth(input int ver);
    if (ver == 1) return 3;
    if (ver == 2) return 4;
    return 6;
  endfunction

  function automatic int statWidth(input int ver);
    return (ver == 7) ? 10 : 5;
  endfunction

  function automatic logic [DATA_W-1:0] lowMask(input int w);
    if (w >= DATA_W) return '1;
    return (DATA_W'(1) << w) - DATA_W'(1);
  endfunction

  function automatic logic isMapped(input logic [ADDR_W-1:0] a);
    case (a[4:3])
      2'b00:        return (a == A_DCTRL) || (a == A_DSTAT) || (a == A_VCATCH) ||
                           (a == A_CHCTRL) || (a == A_CHDATA);
      2'b01, 2'b10: return a[2:0] < 3'd6;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbgscan_ctrl.sv
module dbgscan_ctrl
  import dbgscan_pkg::*;
(
  input  logic              tck,
  input  logic              rstN,
  input  logic              capDr,
  input  logic              shiftDr,
  input  logic              updDr,
  input  logic              dirBit,
  input  logic [ADDR_W-1:0] scanAddr,
  input  logic              dbgTxFull,
  input  logic              dbgRxFull,
  output logic [ADDR_W-1:0] addrLatch,
  output scanStrb_t         strb
);

  // Every update names the address for the following capture
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)      addrLatch <= '0;
    else if (updDr) addrLatch <= scanAddr;
  end

  always_comb begin
    strb.load    = capDr;
    strb.shift   = shiftDr & ~capDr;
    strb.write   = updDr & dirBit;
    strb.post    = updDr & dirBit & (scanAddr == A_CHDATA) & ~dbgTxFull;
    strb.consume = capDr & (addrLatch == A_CHDATA) & dbgRxFull;
  end

endmodule

// File: rtl/dbgscan_chan.sv
module dbgscan_chan
  import dbgscan_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              tck,
  input  logic              clk,
  input  logic              rstN,
  // test clock side
  input  logic              post,
  input  logic [DATA_W-1:0] postWord,
  input  logic              consume,
  output logic              dbgTxFull,
  output logic              dbgRxFull,
  output logic [DATA_W-1:0] dbgRxWord,
  // core clock side
  input  logic              coreWrStb,
  input  logic [DATA_W-1:0] coreWrData,
  input  logic              coreRdStb,
  output logic [DATA_W-1:0] coreRdData,
  output logic              coreRxValid,
  output logic              coreTxBusy
);

  logic              d2cTog, d2cAck, c2dTog, c2dAck;
  logic [SYNC_N-1:0] d2cTogSync, d2cAckSync, c2dTogSync, c2dAckSync;
  logic              d2cSeen, d2cAckSeen, c2dSeen, c2dAckSeen;
  logic [DATA_W-1:0] txWord, coreWord;

  // Test clock domain
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      d2cTog     <= 1'b0;
      c2dAck     <= 1'b0;
      d2cAckSync <= '0;
      c2dTogSync <= '0;
      d2cAckSeen <= 1'b0;
      c2dSeen    <= 1'b0;
      dbgTxFull  <= 1'b0;
      dbgRxFull  <= 1'b0;
      txWord     <= '0;
    end else begin
      d2cAckSync <= {d2cAckSync[SYNC_N-2:0], d2cAck};
      c2dTogSync <= {c2dTogSync[SYNC_N-2:0], c2dTog};
      d2cAckSeen <= d2cAckSync[SYNC_N-1];
      c2dSeen    <= c2dTogSync[SYNC_N-1];
      if (d2cAckSync[SYNC_N-1] != d2cAckSeen) dbgTxFull <= 1'b0;
      if (post) begin
        txWord    <= postWord;
        d2cTog    <= ~d2cTog;
        dbgTxFull <= 1'b1;
      end
      if (c2dTogSync[SYNC_N-1] != c2dSeen) dbgRxFull <= 1'b1;
      if (consume) begin
        dbgRxFull <= 1'b0;
        c2dAck    <= ~c2dAck;
      end
    end
  end

  // Core clock domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      c2dTog      <= 1'b0;
      d2cAck      <= 1'b0;
      d2cTogSync  <= '0;
      c2dAckSync  <= '0;
      d2cSeen     <= 1'b0;
      c2dAckSeen  <= 1'b0;
      coreRxValid <= 1'b0;
      coreTxBusy  <= 1'b0;
      coreWord    <= '0;
    end else begin
      d2cTogSync <= {d2cTogSync[SYNC_N-2:0], d2cTog};
      c2dAckSync <= {c2dAckSync[SYNC_N-2:0], c2dAck};
      d2cSeen    <= d2cTogSync[SYNC_N-1];
      c2dAckSeen <= c2dAckSync[SYNC_N-1];
      if (d2cTogSync[SYNC_N-1] != d2cSeen) coreRxValid <= 1'b1;
      if (coreRdStb && coreRxValid) begin
        coreRxValid <= 1'b0;
        d2cAck      <= ~d2cAck;
      end
      if (c2dAckSync[SYNC_N-1] != c2dAckSeen) coreTxBusy <= 1'b0;
      if (coreWrStb && !coreTxBusy) begin
        coreWord   <= coreWrData;
        c2dTog     <= ~c2dTog;
        coreTxBusy <= 1'b1;
      end
    end
  end

  // Words stay stable while their flag is set, so they cross as plain data
  assign coreRdData = txWord;
  assign dbgRxWord  = coreWord;

endmodule

// File: rtl/dbgscan_regs.sv
module dbgscan_regs
  import dbgscan_pkg::*;
#(
  parameter int VERSION    = 7,
  parameter bit HAS_VCATCH = 1'b1,
  parameter int VC_W       = 8,
  parameter int WP_CTL_W   = 9
) (
  input  logic                            tck,
  input  logic                            rstN,
  input  logic                            tdi,
  input  scanStrb_t                       strb,
  input  logic [ADDR_W-1:0]               addrLatch,
  input  logic [STAT_MAX_W-1:0]           statusIn,
  input  logic                            dbgTxFull,
  input  logic                            dbgRxFull,
  input  logic [DATA_W-1:0]               dbgRxWord,
  output logic [SCAN_W-1:0]               shiftReg,
  output logic                            tdo,
  output logic [CTRL_MAX_W-1:0]           dbgCtrl,
  output logic [VC_W-1:0]                 vecCatch,
  output logic [WP_TOTAL-1:0][DATA_W-1:0] wpRegs
);

  localparam int                CTRL_W    = ctrlWidth(VERSION);
  localparam int                STAT_W    = statWidth(VERSION);
  localparam logic [DATA_W-1:0] CTRL_MASK = lowMask(CTRL_W);
  localparam logic [DATA_W-1:0] STAT_MASK = lowMask(STAT_W);
  localparam logic [DATA_W-1:0] VC_MASK   = lowMask(VC_W);
  localparam logic [3:0]        VER_CODE  = 4'(VERSION);

  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] rdData;

  assign wrAddr = shiftReg[DATA_W +: ADDR_W];
  assign wrData = shiftReg[DATA_W-1:0];

  // Scan register: capture, then shift toward tdo
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)           shiftReg <= '0;
    else if (strb.load)  shiftReg <= {1'b0, addrLatch, rdData};
    else if (strb.shift) shiftReg <= {tdi, shiftReg[SCAN_W-1:1]};
  end
  assign tdo = shiftReg[0];

  // Debug control
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)                                dbgCtrl <= '0;
    else if (strb.write && wrAddr == A_DCTRL) dbgCtrl <= wrData[CTRL_MAX_W-1:0] & CTRL_MASK[CTRL_MAX_W-1:0];
  end

  // Optional vector catch
  generate
    if (HAS_VCATCH) begin : g_vc
      always_ff @(posedge tck or negedge rstN) begin
        if (!rstN)                                 vecCatch <= '0;
        else if (strb.write && wrAddr == A_VCATCH) vecCatch <= wrData[VC_W-1:0] & VC_MASK[VC_W-1:0];
      end
    end else begin : g_no_vc
      assign vecCatch = '0;
    end
  endgenerate

  // Watchpoint units: address, data and control value/mask pairs
  generate
    for (genvar g = 0; g < WP_TOTAL; g++) begin : g_wp
      localparam int                WIDX = g % WP_PER;
      localparam logic [ADDR_W-1:0] WADR = ((g / WP_PER) == 0 ? A_WP0 : A_WP1) + ADDR_W'(WIDX);
      localparam logic [DATA_W-1:0] WMSK = (WIDX >= 4) ? lowMask(WP_CTL_W) : lowMask(DATA_W);
      logic [DATA_W-1:0] wpQ;
      always_ff @(posedge tck or negedge rstN) begin
        if (!rstN)                             wpQ <= '0;
        else if (strb.write && wrAddr == WADR) wpQ <= wrData & WMSK;
      end
      assign wpRegs[g] = wpQ;
    end
  endgenerate

  // Read multiplexer for the latched address
  always_comb begin
    rdData = '0;
    case (addrLatch)
      A_DCTRL:  rdData = DATA_W'(dbgCtrl);
      A_DSTAT:  rdData = DATA_W'(statusIn) & STAT_MASK;
      A_VCATCH: rdData = DATA_W'(vecCatch);
      A_CHCTRL: rdData = {VER_CODE, 26'd0, dbgRxFull, dbgTxFull};
      A_CHDATA: rdData = dbgRxWord;
      default: begin
        if ((addrLatch[4:3] == 2'b01 || addrLatch[4:3] == 2'b10) && addrLatch[2:0] < 3'd6)
          rdData = wpRegs[(addrLatch[4] ? WP_PER : 0) + int'(addrLatch[2:0])];
      end
    endcase
  end

endmodule

// File: rtl/dbgscan_port.sv
module dbgscan_port
  import dbgscan_pkg::*;
#(
  parameter int VERSION    = 7,
  parameter bit HAS_VCATCH = 1'b1,
  parameter int VC_W       = 8,
  parameter int WP_CTL_W   = 9,
  parameter int SYNC_N     = 2
) (
  input  logic                            tck,
  input  logic                            rstN,
  input  logic                            capDr,
  input  logic                            shiftDr,
  input  logic                            updDr,
  input  logic                            tdi,
  output logic                            tdo,
  input  logic                            clk,
  input  logic                            coreWrStb,
  input  logic [DATA_W-1:0]               coreWrData,
  input  logic                            coreRdStb,
  output logic [DATA_W-1:0]               coreRdData,
  output logic                            coreRxValid,
  output logic                            coreTxBusy,
  input  logic [STAT_MAX_W-1:0]           statusIn,
  output logic [CTRL_MAX_W-1:0]           dbgCtrl,
  output logic [VC_W-1:0]                 vecCatch,
  output logic [WP_TOTAL-1:0][DATA_W-1:0] wpRegs
);

  scanStrb_t         strb;
  logic [ADDR_W-1:0] addrLatch;
  logic [SCAN_W-1:0] shiftReg;
  logic              dbgTxFull, dbgRxFull;
  logic [DATA_W-1:0] dbgRxWord;

  dbgscan_ctrl ctrl_i (
    .tck(tck), .rstN(rstN), .capDr(capDr), .shiftDr(shiftDr), .updDr(updDr),
    .dirBit(shiftReg[SCAN_W-1]), .scanAddr(shiftReg[DATA_W +: ADDR_W]),
    .dbgTxFull(dbgTxFull), .dbgRxFull(dbgRxFull),
    .addrLatch(addrLatch), .strb(strb)
  );

  dbgscan_regs #(
    .VERSION(VERSION), .HAS_VCATCH(HAS_VCATCH), .VC_W(VC_W), .WP_CTL_W(WP_CTL_W)
  ) regs_i (
    .tck(tck), .rstN(rstN), .tdi(tdi), .strb(strb), .addrLatch(addrLatch),
    .statusIn(statusIn), .dbgTxFull(dbgTxFull), .dbgRxFull(dbgRxFull),
    .dbgRxWord(dbgRxWord), .shiftReg(shiftReg), .tdo(tdo),
    .dbgCtrl(dbgCtrl), .vecCatch(vecCatch), .wpRegs(wpRegs)
  );

  dbgscan_chan #(.SYNC_N(SYNC_N)) chan_i (
    .tck(tck), .clk(clk), .rstN(rstN),
    .post(strb.post), .postWord(shiftReg[DATA_W-1:0]), .consume(strb.consume),
    .dbgTxFull(dbgTxFull), .dbgRxFull(dbgRxFull), .dbgRxWord(dbgRxWord),
    .coreWrStb(coreWrStb), .coreWrData(coreWrData), .coreRdStb(coreRdStb),
    .coreRdData(coreRdData), .coreRxValid(coreRxValid), .coreTxBusy(coreTxBusy)
  );

endmodule

// File: rtl/dbgscan_sva.sv
module dbgscan_sva
  import dbgscan_pkg::*;
#(
  parameter int VERSION = 7,
  parameter int VC_W    = 8
) (
  input logic                            tck,
  input logic                            clk,
  input logic                            rstN,
  input logic                            capDr,
  input logic                            updDr,
  input logic [ADDR_W-1:0]               addrLatch,
  input logic [SCAN_W-1:0]               shiftReg,
  input logic                            dbgTxFull,
  input logic                            dbgRxFull,
  input logic                            coreWrStb,
  input logic                            coreTxBusy,
  input logic [DATA_W-1:0]               coreRdData,
  input logic [CTRL_MAX_W-1:0]           dbgCtrl,
  input logic [VC_W-1:0]                 vecCatch,
  input logic [WP_TOTAL-1:0][DATA_W-1:0] wpRegs
);

  localparam logic [DATA_W-1:0] CTRL_MASK = lowMask(ctrlWidth(VERSION));
  localparam logic [3:0]        VER_CODE  = 4'(VERSION);

  assert_consume_clears_R12: assert property (@(posedge tck) disable iff (!rstN)
    capDr && addrLatch == A_CHDATA && dbgRxFull |=> !dbgRxFull);

  assert_park_no_effect_R12: assert property (@(posedge tck) disable iff (!rstN)
    capDr && addrLatch == A_CHCTRL && dbgRxFull |=> dbgRxFull);

  assert_version_field_R4: assert property (@(posedge tck) disable iff (!rstN)
    capDr && addrLatch == A_CHCTRL |=> shiftReg[31:28] == VER_CODE);

  assert_ctrl_width_R5: assert property (@(posedge tck) disable iff (!rstN)
    (dbgCtrl & ~CTRL_MASK[CTRL_MAX_W-1:0]) == '0);

  assert_unmapped_write_R8: assert property (@(posedge tck) disable iff (!rstN)
    updDr && shiftReg[SCAN_W-1] && !isMapped(shiftReg[DATA_W +: ADDR_W])
    |=> $stable(dbgCtrl) && $stable(wpRegs) && $stable(vecCatch) && $stable(dbgTxFull));

  assert_pending_post_R9: assert property (@(posedge tck) disable iff (!rstN)
    updDr && shiftReg[SCAN_W-1] && shiftReg[DATA_W +: ADDR_W] == A_CHDATA && dbgTxFull
    |=> $stable(coreRdData) && dbgTxFull);

  assert_core_post_R11: assert property (@(posedge clk) disable iff (!rstN)
    coreWrStb && !coreTxBusy |=> coreTxBusy);

endmodule

bind dbgscan_port dbgscan_sva #(.VERSION(VERSION), .VC_W(VC_W)) sva_i (
  .tck(tck), .clk(clk), .rstN(rstN), .capDr(capDr), .updDr(updDr),
  .addrLatch(addrLatch), .shiftReg(shiftReg), .dbgTxFull(dbgTxFull),
  .dbgRxFull(dbgRxFull), .coreWrStb(coreWrStb), .coreTxBusy(coreTxBusy),
  .coreRdData(coreRdData), .dbgCtrl(dbgCtrl), .vecCatch(vecCatch), .wpRegs(wpRegs)
);

// File: tb/dbgscan_port_tb_top.sv
module dbgscan_port_tb_top;

  logic tck = 1'b0, clk = 1'b0, rstN = 1'b0;
  logic capDr = 1'b0, shiftDr = 1'b0, updDr = 1'b0, tdi = 1'b0;
  logic coreWrStb = 1'b0, coreRdStb = 1'b0;
  logic [31:0] coreWrData = '0;
  logic [9:0]  statusIn = 10'h2D6;
  logic tdo0, tdo1;
  logic [31:0] rdData0, rdData1;
  logic rxValid0, rxValid1, txBusy0, txBusy1;
  logic [5:0] ctrl0, ctrl1;
  logic [7:0] vc0, vc1;
  logic [11:0][31:0] wp0, wp1;

  int checks = 0;
  int failures = 0;

  always #5  clk = ~clk;
  always #20 tck = ~tck;

  dbgscan_port dut_i (
    .tck(tck), .rstN(rstN), .capDr(capDr), .shiftDr(shiftDr), .updDr(updDr),
    .tdi(tdi), .tdo(tdo0), .clk(clk), .coreWrStb(coreWrStb), .coreWrData(coreWrData),
    .coreRdStb(coreRdStb), .coreRdData(rdData0), .coreRxValid(rxValid0),
    .coreTxBusy(txBusy0), .statusIn(statusIn), .dbgCtrl(ctrl0), .vecCatch(vc0),
    .wpRegs(wp0)
  );

  // Small variant: lowest version, no vector catch
  dbgscan_port #(.VERSION(1), .HAS_VCATCH(1'b0)) dut1_i (
    .tck(tck), .rstN(rstN), .capDr(capDr), .shiftDr(shiftDr), .updDr(updDr),
    .tdi(tdi), .tdo(tdo1), .clk(clk), .coreWrStb(coreWrStb), .coreWrData(coreWrData),
    .coreRdStb(coreRdStb), .coreRdData(rdData1), .coreRxValid(rxValid1),
    .coreTxBusy(txBusy1), .statusIn(statusIn), .dbgCtrl(ctrl1), .vecCatch(vc1),
    .wpRegs(wp1)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int a);
    return 32'h9E37_79B9 * 32'(a + 1);
  endfunction

  // Expected read value after the sweep, from the requirements
  function automatic logic [31:0] expRd(input int ver, input bit vc, input int a);
    int cw = (ver == 1) ? 3 : (ver == 2) ? 4 : 6;
    int sw = (ver == 7) ? 10 : 5;
    if (a == 0) return pat(a) & ((32'd1 << cw) - 1);
    if (a == 1) return 32'(statusIn) & ((32'd1 << sw) - 1);
    if (a == 2) return vc ? (pat(a) & 32'hFF) : 32'd0;
    if (a == 4) return {4'(ver), 28'd0};
    if (a == 5) return 32'd0;
    if ((a >= 8 && a <= 13) || (a >= 16 && a <= 21))
      return ((a % 8) >= 4) ? (pat(a) & 32'h1FF) : pat(a);
    return 32'd0;
  endfunction

  task automatic scan(input logic dir, input logic [4:0] addr, input logic [31:0] data,
                      output logic [37:0] cap0, output logic [37:0] cap1);
    logic [37:0] vec;
    vec = {dir, addr, data};
    @(negedge tck); capDr = 1'b1;
    @(negedge tck); capDr = 1'b0; shiftDr = 1'b1;
    for (int i = 0; i < 38; i++) begin
      cap0[i] = tdo0;
      cap1[i] = tdo1;
      tdi = vec[i];
      @(negedge tck);
    end
    shiftDr = 1'b0; updDr = 1'b1;
    @(negedge tck); updDr = 1'b0;
  endtask

  task automatic writeReg(input logic [4:0] addr, input logic [31:0] data);
    logic [37:0] c0, c1;
    scan(1'b1, addr, data, c0, c1);
  endtask

  // Name the address, then park on channel control while its data comes out
  task automatic readReg(input logic [4:0] addr, output logic [37:0] c0, output logic [37:0] c1);
    logic [37:0] d0, d1;
    scan(1'b0, addr, 32'd0, d0, d1);
    scan(1'b0, 5'd4, 32'd0, c0, c1);
  endtask

  initial begin
    #3_000_000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [37:0] c0, c1;
    logic [11:0][31:0] wpBefore;
    repeat (3) @(negedge tck);
    rstN = 1'b1;
    @(negedge tck);

    // R13: reset state
    chk("R13 rxValid", 64'(rxValid0), 64'd0);
    chk("R13 txBusy", 64'(txBusy0), 64'd0);
    chk("R13 dbgCtrl", 64'(ctrl0), 64'd0);
    chk("R13 wp entry 0", 64'(wp0[0]), 64'd0);
    readReg(5'd9, c0, c1);
    chk("R13 wp read zero", 64'(c0[31:0]), 64'd0);

    // R1 R2 R7 R5 R8 R4: write sweep over all addresses except channel data
    for (int a = 0; a < 32; a++)
      if (a != 5) writeReg(5'(a), pat(a));

    // R3: read data returns with echoed address and cleared direction bit
    readReg(5'd8, c0, c1);
    chk("R3 address echo", 64'(c0[37:32]), 64'(6'd8));
    chk("R1 R2 R3 wp read", 64'(c0[31:0]), 64'(pat(8)));

    for (int a = 0; a < 32; a++) begin
      readReg(5'(a), c0, c1);
      chk($sformatf("R7 R8 R5 R4 sweep v7 addr %0d", a), 64'(c0[31:0]), 64'(expRd(7, 1'b1, a)));
      chk($sformatf("R7 R8 R5 R4 sweep v1 addr %0d", a), 64'(c1[31:0]), 64'(expRd(1, 1'b0, a)));
    end
    chk("R7 vecCatch output", 64'(vc0), 64'(pat(2) & 32'hFF));
    chk("R7 wp unit1 ctl mask output", 64'(wp0[11]), 64'(pat(21) & 32'h1FF));

    // R8: write to an unmapped address leaves every register alone
    wpBefore = wp0;
    writeReg(5'd7, 32'hFFFF_FFFF);
    chk("R8 unmapped write wp", 64'(wp0 == wpBefore), 64'd1);
    chk("R8 unmapped write ctrl", 64'(ctrl0), 64'(pat(0) & 32'h3F));

    // R6 R5: monitor enable bit and width per version
    writeReg(5'd0, 32'h0000_003F);
    chk("R6 monitor on", 64'(ctrl0[4]), 64'd1);
    chk("R5 v1 ctrl width", 64'(ctrl1), 64'h7);
    writeReg(5'd0, 32'h0000_002F);
    chk("R6 halting selected", 64'(ctrl0), 64'h2F);

    // R9 R10: debugger to core
    writeReg(5'd5, 32'h1234_5678);
    repeat (3) @(negedge tck);
    chk("R9 rxValid", 64'(rxValid0), 64'd1);
    chk("R9 word", 64'(rdData0), 64'h1234_5678);
    readReg(5'd4, c0, c1);
    chk("R4 bit0 pending", 64'(c0[31:0]), 64'h7000_0001);
    writeReg(5'd5, 32'hDEAD_BEEF);
    repeat (3) @(negedge tck);
    chk("R9 pending write ignored", 64'(rdData0), 64'h1234_5678);
    @(negedge clk); coreRdStb = 1'b1;
    @(negedge clk); coreRdStb = 1'b0;
    chk("R10 rxValid cleared", 64'(rxValid0), 64'd0);
    repeat (4) @(negedge tck);
    readReg(5'd4, c0, c1);
    chk("R10 bit0 cleared", 64'(c0[31:0]), 64'h7000_0000);

    // R11 R12: core to debugger, parked reads first
    @(negedge clk); coreWrStb = 1'b1; coreWrData = 32'hCAFE_0001;
    @(negedge clk); coreWrStb = 1'b0;
    chk("R11 busy set", 64'(txBusy0), 64'd1);
    @(negedge clk); coreWrStb = 1'b1; coreWrData = 32'hBAD0_0002;
    @(negedge clk); coreWrStb = 1'b0;
    repeat (4) @(negedge tck);
    readReg(5'd4, c0, c1);
    chk("R11 bit1 set", 64'(c0[31:0]), 64'h7000_0002);
    readReg(5'd4, c0, c1);
    chk("R12 parked read keeps flag", 64'(c0[31:0]), 64'h7000_0002);
    chk("R12 parked read keeps busy", 64'(txBusy0), 64'd1);
    readReg(5'd5, c0, c1);
    chk("R11 R12 consumed word", 64'(c0[31:0]), 64'hCAFE_0001);
    repeat (4) @(negedge tck);
    chk("R12 busy cleared", 64'(txBusy0), 64'd0);
    readReg(5'd4, c0, c1);
    chk("R12 bit1 cleared", 64'(c0[31:0]), 64'h7000_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule